// File: doc/BRIEF.md
# Cascadable Framed Serial Codec Port

This block is the digital serial port of one codec unit. Several units can be chained on a single host serial port. The block divides the system clock down to a serial clock, which it drives out. It sends 16-bit words on a data output, each one marked by its own output frame sync. It receives 16-bit words on a data input, each one marked by an input frame sync. A one-cycle sample strobe starts each output burst. The first word of every burst is the converter result presented on `adc_word` at the strobe.

No unit in the chain has a chip select or an address. Instead, each unit counts the input frame syncs it has seen since the last strobe. It compares that count with a 3-bit cascade-length register, which holds the number of units minus one. Input words whose index is below the cascade length are forwarded: each one goes out on the data output in the word slot after it arrived. The word whose index equals the cascade length is written into the DAC holding register.

In a chain of N units, the host sends the word meant for unit k at position N-1-k. The host then receives the converter words of units N-1 down to 0. A mode input lets the unit use its own output frame sync as its input frame sync. In that mode, input and output words are forced to line up.

Top module: `cascade_serial_port`

## Requirements
- R1: `ser_clk` is a square wave with a period of 2*SCLK_HALF system clocks. While reset is held, `ser_clk`, `ser_out`, `fs_out`, `dac_word` and `dac_load` are all 0.
- R2: Output words are 16 bits long and sent most significant bit first. Each bit changes on a rising edge of `ser_clk`. `fs_out` is high for exactly one bit period. That period is either the one just before the first bit, or the last bit of the previous word when the next word follows without a gap.
- R3: `fs_out` goes high at the first rising edge of `ser_clk` after `smp_strobe`. The word that follows is the `adc_word` value captured on the strobe cycle.
- R4: Input is sampled on falling edges of `ser_clk`. When the input frame sync is high at a falling edge, the next 16 falling edges carry one word, most significant bit first. A frame sync that coincides with the 16th bit completes that word and also opens the next one.
- R5: The input frame-sync count clears at `smp_strobe`, and its index is 0-based. The word whose index equals the cascade length is written to `dac_word`, and `dac_load` pulses for one cycle. This happens exactly once per sample interval.
- R6: The cascade-length register is loaded from `cfg_len` when `cfg_wr` is high, and it resets to 0. With the reset value, the first input word after a strobe is written to the DAC register and nothing is forwarded.
- R7: An input word whose index is below the cascade length is sent out in the next word slot. It follows the previous output word without a gap, so a burst holds cascade length + 1 words. Words with an index at or above the cascade length are never forwarded.
- R8: With `loop_fs` = 1, the `fs_in` pin is ignored and the unit's own `fs_out` acts as its input frame sync.
- R9: A frame sync that arrives before the 16th bit of a word discards the partial word and restarts the bit count. It does not advance the frame index.
- R10: In a chain of N units (N from 1 to 8), each unit loads exactly the host word at position N-1-k. The host receives converter words in order from unit N-1 down to unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe | input | 1 | One-cycle pulse that marks the start of a sample interval |
| cfg_wr | input | 1 | Write enable for the cascade-length register |
| cfg_len | input | 3 | Number of chained units minus one |
| loop_fs | input | 1 | 1: use the unit's own output frame sync as the input frame sync |
| adc_word | input | 16 | Converter word sent first in each burst |
| ser_in | input | 1 | Serial data input |
| fs_in | input | 1 | Input frame sync, active high |
| ser_clk | output | 1 | Generated serial clock |
| ser_out | output | 1 | Serial data output |
| fs_out | output | 1 | Output frame sync, active high |
| dac_word | output | 16 | DAC holding register |
| dac_load | output | 1 | One-cycle pulse when `dac_word` is updated |

## Verification
A wrong frame-sync count in any unit moves every word loaded downstream. The fault appears at the end of the same sample interval: a unit loads the wrong host word, or its DAC register is loaded zero times or twice. A wrong forwarding decision shows at the host serial input within one word slot, as a missing frame sync, an extra word, or converter words out of order. A bit-counter fault caused by a mid-word frame sync shows as a wrong value in the DAC register once the restarted word has finished.

// File: rtl/cport_pkg.sv
package cport_pkg;

    localparam int WORD_W    = 16;
    localparam int CASC_W    = 3;
    localparam int MAX_UNITS = 1 << CASC_W;
    localparam int IDX_W     = CASC_W + 1;
    localparam int BCNT_W    = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CASC_W-1:0] casc_t;
    typedef logic [IDX_W-1:0]  fidx_t;
    typedef logic [BCNT_W-1:0] bcnt_t;

    typedef struct packed {
        logic  valid;
        fidx_t idx;
        word_t data;
    } rx_word_t;

    function automatic fidx_t fidx_inc(fidx_t v);
        return (v == {IDX_W{1'b1}}) ? v : v + fidx_t'(1);
    endfunction

    function automatic word_t shift_in(word_t v, logic b);
        return {v[WORD_W-2:0], b};
    endfunction

endpackage

// File: rtl/cport_clkgen.sv
module cport_clkgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF - 1));
    assign rise_tick = wrap & ~sclk;
    assign fall_tick = wrap & sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/cport_rx.sv
module cport_rx
    import cport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fall_tick,
    input  logic     clear,
    input  logic     bit_in,
    input  logic     fs,
    output rx_word_t done_o,
    output logic     busy_o,
    output fidx_t    cur_idx_o
);
    localparam bcnt_t LAST = bcnt_t'(WORD_W - 1);

    logic  active;
    bcnt_t cnt;
    word_t sh;
    fidx_t idx;
    fidx_t fcnt;
    logic  partial;

    assign partial   = active && (cnt != LAST);
    assign busy_o    = active;
    assign cur_idx_o = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            idx    <= '0;
            fcnt   <= '0;
            done_o <= '0;
        end else begin
            done_o.valid <= 1'b0;
            if (fall_tick) begin
                if (active) begin
                    if (cnt == LAST) begin
                        done_o <= '{valid: 1'b1, idx: idx, data: shift_in(sh, bit_in)};
                        active <= 1'b0;
                    end else begin
                        sh  <= shift_in(sh, bit_in);
                        cnt <= cnt + bcnt_t'(1);
                    end
                end
                if (fs) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    if (!partial) begin
                        idx  <= fcnt;
                        fcnt <= fidx_inc(fcnt);
                    end
                end
            end
            if (clear) begin
                fcnt <= '0;
            end
        end
    end

    // R4: a finished word is reported only right after a sampling edge
    a_r4_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        done_o.valid |-> $past(fall_tick));

    // R9: an aborted partial word never surfaces as a finished word
    a_r9_abort_silent: assert property (@(posedge clk) disable iff (rst)
        (fall_tick && fs && partial) |=> !done_o.valid);

endmodule

// File: rtl/cport_tx.sv
module cport_tx
    import cport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_tick,
    input  logic  start_req,
    input  word_t first_word,
    input  logic  push,
    input  word_t push_data,
    input  logic  more_hint,
    output logic  sdo,
    output logic  sdofs
);
    localparam bcnt_t LAST = bcnt_t'(WORD_W - 1);

    logic  pend;
    word_t nxt;
    logic  nxt_vld;
    word_t sh;
    bcnt_t left;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            nxt     <= '0;
            nxt_vld <= 1'b0;
            sh      <= '0;
            left    <= '0;
            sdo     <= 1'b0;
            sdofs   <= 1'b0;
        end else begin
            if (push) begin
                nxt     <= push_data;
                nxt_vld <= 1'b1;
            end
            if (rise_tick) begin
                if (sdofs) begin
                    sdo     <= nxt[WORD_W-1];
                    sh      <= {nxt[WORD_W-2:0], 1'b0};
                    left    <= LAST;
                    nxt_vld <= 1'b0;
                    sdofs   <= 1'b0;
                end else if (left != '0) begin
                    sdo   <= sh[WORD_W-1];
                    sh    <= {sh[WORD_W-2:0], 1'b0};
                    left  <= left - bcnt_t'(1);
                    sdofs <= (left == bcnt_t'(1)) && (nxt_vld || push || more_hint);
                end else begin
                    sdo   <= 1'b0;
                    sdofs <= pend;
                    pend  <= 1'b0;
                end
            end
            if (start_req) begin
                pend    <= 1'b1;
                nxt     <= first_word;
                nxt_vld <= 1'b1;
            end
        end
    end

    // R2: the sync bit only sits at a word boundary, never inside a word
    a_r2_fs_at_boundary: assert property (@(posedge clk) disable iff (rst)
        sdofs |-> (left == '0));

    // R7: when a new word starts, its data has already been delivered
    a_r7_next_word_ready: assert property (@(posedge clk) disable iff (rst)
        (rise_tick && sdofs) |-> nxt_vld);

endmodule

// File: rtl/cascade_serial_port.sv
module cascade_serial_port
    import cport_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_strobe,
    input  logic              cfg_wr,
    input  logic [CASC_W-1:0] cfg_len,
    input  logic              loop_fs,
    input  logic [WORD_W-1:0] adc_word,
    input  logic              ser_in,
    input  logic              fs_in,
    output logic              ser_clk,
    output logic              ser_out,
    output logic              fs_out,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_load
);
    logic     rise_tick, fall_tick;
    logic     fs_int;
    casc_t    casc_q;
    rx_word_t rx_done;
    logic     rx_busy;
    fidx_t    rx_idx;
    logic     take, fwd, more;

    cport_clkgen #(.HALF(SCLK_HALF)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .sclk      (ser_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign fs_int = loop_fs ? fs_out : fs_in;

    cport_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .fall_tick (fall_tick),
        .clear     (smp_strobe),
        .bit_in    (ser_in),
        .fs        (fs_int),
        .done_o    (rx_done),
        .busy_o    (rx_busy),
        .cur_idx_o (rx_idx)
    );

    assign take = rx_done.valid && (rx_done.idx == fidx_t'(casc_q));
    assign fwd  = rx_done.valid && (rx_done.idx <  fidx_t'(casc_q));
    assign more = rx_busy && (rx_idx < fidx_t'(casc_q));

    cport_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .rise_tick  (rise_tick),
        .start_req  (smp_strobe),
        .first_word (adc_word),
        .push       (fwd),
        .push_data  (rx_done.data),
        .more_hint  (more),
        .sdo        (ser_out),
        .sdofs      (fs_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            casc_q   <= '0;
            dac_word <= '0;
            dac_load <= 1'b0;
        end else begin
            if (cfg_wr) begin
                casc_q <= cfg_len;
            end
            dac_load <= take;
            if (take) begin
                dac_word <= rx_done.data;
            end
        end
    end

    logic [1:0] loads_seen;
    always_ff @(posedge clk) begin
        if (rst || smp_strobe) begin
            loads_seen <= '0;
        end else if (dac_load && loads_seen != 2'd3) begin
            loads_seen <= loads_seen + 2'd1;
        end
    end

    // R5: at most one DAC update per sample interval
    a_r5_single_load: assert property (@(posedge clk) disable iff (rst)
        dac_load |-> (loads_seen == 2'd0));

endmodule

// File: tb/cascade_serial_port_tb.sv
`timescale 1ns/1ps
module cascade_serial_port_tb_top;

    localparam int NU   = 8;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_len = 3'd0;
    logic loop_fs = 1'b0;
    logic host_sdi = 1'b0;
    logic host_fs = 1'b0;

    logic [15:0] adc   [NU];
    logic [15:0] hw    [NU];
    logic        in_d  [NU];
    logic        in_f  [NU];
    logic        sclk_w[NU];
    logic        sdo_w [NU];
    logic        fs_w  [NU];
    logic [15:0] dac_w [NU];
    logic        load_w[NU];

    int n_chk = 0;
    int n_fail = 0;
    int load_cnt[NU];
    logic [15:0] last_dac[NU];
    logic [15:0] exp_q[$];
    int mon_sel = 0;
    int iv = 0;

    always #10 clk = ~clk;

    for (genvar k = 0; k < NU; k++) begin : chain
        if (k == 0) begin : g_head
            assign in_d[k] = host_sdi;
            assign in_f[k] = host_fs;
        end else begin : g_link
            assign in_d[k] = sdo_w[k-1];
            assign in_f[k] = fs_w[k-1];
        end
        cascade_serial_port #(.SCLK_HALF(HALF)) dut_i (
            .clk        (clk),
            .rst        (rst),
            .smp_strobe (strobe),
            .cfg_wr     (cfg_wr),
            .cfg_len    (cfg_len),
            .loop_fs    (loop_fs),
            .adc_word   (adc[k]),
            .ser_in     (in_d[k]),
            .fs_in      (in_f[k]),
            .ser_clk    (sclk_w[k]),
            .ser_out    (sdo_w[k]),
            .fs_out     (fs_w[k]),
            .dac_word   (dac_w[k]),
            .dac_load   (load_w[k])
        );
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int k = 0; k < NU; k++) begin
            load_cnt[k] = 0;
            last_dac[k] = '0;
        end
        forever begin
            @(negedge clk);
            for (int k = 0; k < NU; k++) begin
                if (load_w[k]) begin
                    load_cnt[k]++;
                    last_dac[k] = dac_w[k];
                end
            end
        end
    end

    // Monitor: decodes the word stream arriving at the host and scores it
    initial begin
        bit m_act = 0;
        int m_cnt = 0;
        logic [15:0] m_sh = '0;
        logic [15:0] e;
        forever begin
            @(negedge sclk_w[0]);
            #1;
            if (m_act) begin
                m_sh = {m_sh[14:0], sdo_w[mon_sel]};
                m_cnt++;
                if (m_cnt == 16) begin
                    m_act = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected host word", 32'(m_sh), 32'hx);
                    end else begin
                        e = exp_q.pop_front();
                        chk(m_sh == e, "R2 R3 R10", "host word order", 32'(m_sh), 32'(e));
                    end
                end
            end
            if (fs_w[mon_sel]) begin
                m_act = 1;
                m_cnt = 0;
            end
        end
    end

    task automatic pulse_strobe();
        @(negedge clk) strobe = 1'b1;
        @(negedge clk) strobe = 1'b0;
    endtask

    task automatic write_cfg(input int n);
        @(negedge clk) begin cfg_len = 3'(n - 1); cfg_wr = 1'b1; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic drive_host(input int n, input bit lp);
        @(posedge sclk_w[0]); #1;
        chk(fs_w[0] == 1'b1, "R3", "sync at first rising edge", 32'(fs_w[0]), 32'd1);
        host_fs = !lp; host_sdi = 1'b0;
        for (int w = 0; w < n; w++) begin
            for (int b = 15; b >= 0; b--) begin
                @(posedge sclk_w[0]); #1;
                host_sdi = hw[w][b];
                host_fs  = !lp && (b == 0) && (w != n - 1);
            end
        end
        @(posedge sclk_w[0]); #1;
        host_fs = 1'b0; host_sdi = 1'b0;
    endtask

    task automatic run_interval(input int n, input bit lp, input bit wr);
        int base[NU];
        iv++;
        if (wr) write_cfg(n);
        loop_fs = lp;
        mon_sel = n - 1;
        for (int k = 0; k < NU; k++) begin
            adc[k] = 16'hA5C3 ^ 16'(k * 16'h1357) ^ 16'(iv * 16'h0F1E);
            hw[k]  = 16'h3C96 + 16'(k * 16'h2461) + 16'(iv * 16'h0777);
            base[k] = load_cnt[k];
        end
        for (int s = 0; s < n; s++) exp_q.push_back(adc[n - 1 - s]);
        pulse_strobe();
        drive_host(n, lp);
        repeat (80) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "burst length", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        for (int k = 0; k < n; k++) begin
            chk(load_cnt[k] - base[k] == 1, "R5", "loads per interval",
                32'(load_cnt[k] - base[k]), 32'd1);
            chk(last_dac[k] == hw[n - 1 - k], lp ? "R8 R10" : "R10", "unit DAC word",
                32'(last_dac[k]), 32'(hw[n - 1 - k]));
        end
    endtask

    task automatic run_abort();
        int base0;
        logic [15:0] wd;
        iv++;
        loop_fs = 1'b0;
        mon_sel = 0;
        wd = 16'h6B2D;
        adc[0] = 16'h0F5A;
        base0 = load_cnt[0];
        exp_q.push_back(adc[0]);
        pulse_strobe();
        @(posedge sclk_w[0]); #1; host_fs = 1'b1; host_sdi = 1'b0;
        for (int b = 0; b < 8; b++) begin
            @(posedge sclk_w[0]); #1; host_fs = 1'b0; host_sdi = 1'b1;
        end
        @(posedge sclk_w[0]); #1; host_fs = 1'b1; host_sdi = 1'b1;
        for (int b = 15; b >= 0; b--) begin
            @(posedge sclk_w[0]); #1; host_fs = 1'b0; host_sdi = wd[b];
        end
        @(posedge sclk_w[0]); #1; host_sdi = 1'b0;
        repeat (80) @(negedge clk);
        chk(load_cnt[0] - base0 == 1, "R9", "loads after restart", 32'(load_cnt[0] - base0), 32'd1);
        chk(last_dac[0] == wd, "R9", "word after restart", 32'(last_dac[0]), 32'(wd));
        chk(exp_q.size() == 0, "R9", "host word count", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        time t0, t1;
        for (int k = 0; k < NU; k++) begin adc[k] = '0; hw[k] = '0; end
        repeat (4) @(negedge clk);
        chk(sclk_w[0] == 1'b0, "R1", "reset sclk", 32'(sclk_w[0]), 32'd0);
        chk(sdo_w[0] == 1'b0 && fs_w[0] == 1'b0, "R1", "reset data/sync",
            32'({sdo_w[0], fs_w[0]}), 32'd0);
        chk(dac_w[0] == 16'h0 && load_w[0] == 1'b0, "R1", "reset DAC",
            32'({load_w[0], dac_w[0]}), 32'd0);
        @(negedge clk) rst = 1'b0;
        @(posedge sclk_w[0]); t0 = $time;
        @(posedge sclk_w[0]); t1 = $time;
        chk((t1 - t0) == 2 * HALF * 20, "R1", "sclk period", 32'(t1 - t0), 32'(2 * HALF * 20));

        run_interval(1, 1'b0, 1'b0);   // R6: reset cascade length, single unit
        run_abort();                    // R9
        run_interval(3, 1'b0, 1'b1);   // R4 R7 R10
        run_interval(8, 1'b0, 1'b1);   // full chain
        run_interval(8, 1'b1, 1'b0);   // R8 loopback
        run_interval(2, 1'b1, 1'b1);
        run_interval(5, 1'b0, 1'b1);
        run_interval(1, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(64'd200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule